// File: doc/BRIEF.md
# Nonvolatile configuration lock controller

This block models a small bank of nonvolatile configuration bits and decides, request by request, whether a write or an erase may touch them. It carries a storage-area lock, a low-voltage programming enable, a reset-pin enable, two code-protection bits (program memory and data memory) and a storage-area size field. Requests arrive from a programming port, which also tells whether it is running in low-voltage or high-voltage mode, or come from running code as a self-erase.

The enables that protect something are active low: 0 means the protection is on. Programming only moves bits from 1 to 0. An erase sets every bit back to 1, but only while the storage area is unlocked. Once the lock bit is 0 it stays 0. A write over the low-voltage port may not clear the low-voltage enable. When that enable is off, the low-voltage port is refused altogether. The reset-pin function and the protection flags are decoded from the stored bits.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: On reset the configuration loads from parameter INIT_CFG (default all ones). The bit layout is: bit 0 low-voltage enable, bit 1 reset-pin enable, bit 2 lock (active low), bit 3 program protection (active low), bit 4 data protection (active low), bits 5 and up the size field. No response is pending out of reset.
- R2: An accepted write (op 0) sets the configuration to old AND data. A 1 in the data never raises a bit.
- R3: An accepted bulk erase (op 1) or self-erase (op 2) sets every configuration bit to 1.
- R4: Once the lock bit reads 0 it never reads 1 again, whatever is requested.
- R5: While locked, bulk erase and self-erase are rejected and change nothing. The size bits can still be written from 1 to 0 but never go from 0 to 1.
- R6: A write whose data bit 0 is 0, flagged as arriving over the low-voltage port (req_lv_i=1), is rejected.
- R7: While the low-voltage enable is 0, any write or bulk erase flagged low-voltage is rejected. The same request flagged high-voltage is judged by the other rules. Self-erase ignores req_lv_i.
- R8: rst_pin_mclr_o is 1 whenever the low-voltage enable is 1. Otherwise it equals the reset-pin enable bit.
- R9: store_locked_o, prog_protected_o and data_protected_o are the inverses of bits 2, 3 and 4.
- R10: Every request sampled on a clock edge gives exactly one resp_valid_o pulse on the following cycle, with resp_ok_o showing accept (1) or reject (0). A rejected request leaves the configuration unchanged. Op 3 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 write, 1 bulk erase, 2 self-erase, 3 reserved |
| req_lv_i | input | 1 | Request comes over the low-voltage port |
| req_data_i | input | SIZE_W+5 | Write data, ANDed into the configuration |
| resp_valid_o | output | 1 | One-cycle done pulse |
| resp_ok_o | output | 1 | Request accepted |
| cfg_o | output | SIZE_W+5 | Current configuration bits |
| rst_pin_mclr_o | output | 1 | Reset pin acts as master clear (0: port function) |
| store_locked_o | output | 1 | Storage area locked |
| prog_protected_o | output | 1 | Program memory protected |
| data_protected_o | output | 1 | Data memory protected |

## Verification
Writes are sent in both port modes, with the low-voltage enable set and then cleared. This separates the rule that guards the enable bit (R6) from the rule that refuses the whole port (R7). Bulk erase and self-erase are each issued unlocked and then locked, which shows that the lock gates the erases and does not merely mask individual bits. Writes with 1s in the data are sent over bits already at 0, to show that a write never raises a bit; this includes trying to raise the lock and the size field. The reset-pin output is observed with the reset-pin enable cleared, once while the low-voltage enable masks it and once after it takes effect.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int BIT_LV    = 0;
  localparam int BIT_RSTP  = 1;
  localparam int BIT_LOCK  = 2;
  localparam int BIT_PPROT = 3;
  localparam int BIT_DPROT = 4;
  localparam int SIZE_LSB  = 5;

  typedef enum logic [1:0] {
    OP_WRITE      = 2'd0,
    OP_BULK_ERASE = 2'd1,
    OP_SELF_ERASE = 2'd2,
    OP_RSVD       = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/cfg_req_judge.sv
module cfg_req_judge
  import cfg_lock_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             req_valid_i,
  input  logic [1:0]       op_i,
  input  logic             lv_port_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic [CFG_W-1:0] cur_i,
  output logic             accept_o,
  output logic             is_write_o,
  output logic [CFG_W-1:0] next_o
);
  logic port_ok;
  logic locked;

  always_comb begin
    port_ok    = !lv_port_i || cur_i[BIT_LV];
    locked     = !cur_i[BIT_LOCK];
    accept_o   = 1'b0;
    is_write_o = 1'b0;
    next_o     = cur_i;
    unique case (cfg_op_e'(op_i))
      OP_WRITE: begin
        is_write_o = 1'b1;
        // low-voltage port may not drop its own enable
        accept_o   = port_ok && !(lv_port_i && !data_i[BIT_LV]);
        next_o     = cur_i & data_i;
      end
      OP_BULK_ERASE: begin
        accept_o = port_ok && !locked;
        next_o   = '1;
      end
      OP_SELF_ERASE: begin
        accept_o = !locked;
        next_o   = '1;
      end
      default: accept_o = 1'b0;
    endcase
    if (!req_valid_i) accept_o = 1'b0;
  end
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
  import cfg_lock_pkg::*;
#(
  parameter int               CFG_W    = 8,
  parameter logic [CFG_W-1:0] INIT_CFG = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             accept_i,
  input  logic             is_write_i,
  input  logic [CFG_W-1:0] next_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             resp_valid_o,
  output logic             resp_ok_o
);
  localparam int SIZE_W = CFG_W - SIZE_LSB;

  logic [CFG_W-1:0] cfg_q;
  logic             upd;

  assign upd = req_valid_i && accept_i;

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[i] <= INIT_CFG[i];
      else if (upd) cfg_q[i] <= next_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_ok_o    <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_ok_o    <= upd;
    end
  end

  assign cfg_o = cfg_q;

  p_lock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[BIT_LOCK] |=> !cfg_q[BIT_LOCK]);

  p_size_no_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[BIT_LOCK] |=>
      ((cfg_q[CFG_W-1:SIZE_LSB] & ~$past(cfg_q[CFG_W-1:SIZE_LSB])) == SIZE_W'(0)));

  p_write_no_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && is_write_i) |=> ((cfg_q & ~$past(cfg_q)) == CFG_W'(0)));

  p_reject_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !accept_i) |=> $stable(cfg_q));

  p_resp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
endmodule

// File: rtl/cfg_pin_decode.sv
module cfg_pin_decode (
  input  logic lv_en_i,
  input  logic rst_pin_en_i,
  input  logic lock_n_i,
  input  logic pprot_n_i,
  input  logic dprot_n_i,
  output logic mclr_o,
  output logic locked_o,
  output logic pprot_o,
  output logic dprot_o
);
  // low-voltage enable forces master clear and masks the pin enable
  assign mclr_o   = lv_en_i ? 1'b1 : rst_pin_en_i;
  assign locked_o = !lock_n_i;
  assign pprot_o  = !pprot_n_i;
  assign dprot_o  = !dprot_n_i;
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int                  SIZE_W   = 3,
  parameter logic [SIZE_W+4:0]   INIT_CFG = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_lv_i,
  input  logic [SIZE_W+4:0] req_data_i,
  output logic              resp_valid_o,
  output logic              resp_ok_o,
  output logic [SIZE_W+4:0] cfg_o,
  output logic              rst_pin_mclr_o,
  output logic              store_locked_o,
  output logic              prog_protected_o,
  output logic              data_protected_o
);
  localparam int CFG_W = SIZE_LSB + SIZE_W;

  logic [CFG_W-1:0] cur_cfg;
  logic [CFG_W-1:0] next_cfg;
  logic             accept;
  logic             is_write;

  cfg_req_judge #(.CFG_W(CFG_W)) u_judge (
    .req_valid_i(req_valid_i),
    .op_i       (req_op_i),
    .lv_port_i  (req_lv_i),
    .data_i     (req_data_i),
    .cur_i      (cur_cfg),
    .accept_o   (accept),
    .is_write_o (is_write),
    .next_o     (next_cfg)
  );

  cfg_bit_store #(.CFG_W(CFG_W), .INIT_CFG(INIT_CFG)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .accept_i    (accept),
    .is_write_i  (is_write),
    .next_i      (next_cfg),
    .cfg_o       (cur_cfg),
    .resp_valid_o(resp_valid_o),
    .resp_ok_o   (resp_ok_o)
  );

  cfg_pin_decode u_pins (
    .lv_en_i     (cur_cfg[BIT_LV]),
    .rst_pin_en_i(cur_cfg[BIT_RSTP]),
    .lock_n_i    (cur_cfg[BIT_LOCK]),
    .pprot_n_i   (cur_cfg[BIT_PPROT]),
    .dprot_n_i   (cur_cfg[BIT_DPROT]),
    .mclr_o      (rst_pin_mclr_o),
    .locked_o    (store_locked_o),
    .pprot_o     (prog_protected_o),
    .dprot_o     (data_protected_o)
  );

  assign cfg_o = cur_cfg;

  p_locked_erase_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && store_locked_o && (req_op_i inside {2'd1, 2'd2})) |=> !resp_ok_o);

  p_lv_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lv_i && req_op_i == 2'd0 && !req_data_i[BIT_LV]) |=> !resp_ok_o);
endmodule

// File: tb/cfg_lock_ctrl_bench.sv
module cfg_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_op = 2'd0;
  logic         req_lv = 1'b0;
  logic [W-1:0] req_data = '1;
  logic         resp_valid, resp_ok, mclr, locked, pprot, dprot;
  logic [W-1:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W:0]   exp_q[$];
  string        tag_q[$];
  logic [W-1:0] model = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lock_ctrl u_cfg_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_lv_i(req_lv), .req_data_i(req_data),
    .resp_valid_o(resp_valid), .resp_ok_o(resp_ok), .cfg_o(cfg),
    .rst_pin_mclr_o(mclr), .store_locked_o(locked),
    .prog_protected_o(pprot), .data_protected_o(dprot)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: called just after a falling edge
  task automatic drive(string tag, logic [1:0] op, logic lv, logic [W-1:0] data);
    logic ok;
    logic [W-1:0] nxt;
    ok  = 1'b0;
    nxt = model;
    case (op)
      2'd0: begin ok = (!lv || model[0]) && !(lv && !data[0]); nxt = model & data; end
      2'd1: begin ok = (!lv || model[0]) && model[2];          nxt = '1; end
      2'd2: begin ok = model[2];                               nxt = '1; end
      default: ok = 1'b0;
    endcase
    if (ok) model = nxt;
    exp_q.push_back({ok, model});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_op = op; req_lv = lv; req_data = data;
    @(negedge clk);
    req_valid = 1'b0; req_data = '1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && resp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10 spurious resp", 32'(resp_valid), 32'd0);
      end else begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " ok"}, 32'(resp_ok), 32'(e[W]));
        chk({t, " cfg"}, 32'(cfg), 32'(e[W-1:0]));
        chk("R8 mclr", 32'(mclr), 32'(e[0] ? 1'b1 : e[1]));
        chk("R9 flags", {29'd0, locked, pprot, dprot}, {29'd0, !e[2], !e[3], !e[4]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", 32'(cfg), 32'hFF);
    chk("R1 reset resp", 32'(resp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg after release", 32'(cfg), 32'hFF);
    chk("R8 mclr after reset", 32'(mclr), 32'd1);

    drive("R8 lv clears pin enable", 2'd0, 1'b1, 8'hFD);
    drive("R6 lv clears lv enable",  2'd0, 1'b1, 8'hFE);
    drive("R7 hv clears lv enable",  2'd0, 1'b0, 8'hFE);
    chk("R8 pin is port function", 32'(mclr), 32'd0);
    drive("R7 lv write while off",   2'd0, 1'b1, 8'hFF);
    drive("R7 lv bulk while off",    2'd1, 1'b1, 8'hFF);
    drive("R3 hv bulk erase",        2'd1, 1'b0, 8'h00);
    drive("R9 set protections",      2'd0, 1'b0, 8'hE7);
    drive("R3 self erase",           2'd2, 1'b1, 8'h00);
    drive("R10 reserved op",         2'd3, 1'b0, 8'h00);
    drive("R4 set lock and size",    2'd0, 1'b0, 8'hDB);
    drive("R5 self erase locked",    2'd2, 1'b0, 8'hFF);
    drive("R5 bulk erase locked",    2'd1, 1'b0, 8'hFF);
    drive("R2 ones write no raise",  2'd0, 1'b0, 8'hFF);
    drive("R5 size program locked",  2'd0, 1'b1, 8'hBF);
    repeat (2) @(negedge clk);
    chk("R4 lock still set", 32'(cfg[2]), 32'd0);
    chk("R5 final cfg", 32'(cfg), 32'h9B);
    chk("R10 queue drained", 32'(exp_q.size()), 32'd0);
    chk("R10 no pending resp", 32'(resp_valid), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule